// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor-side request port and a cache controller and keeps account of every memory request still in flight. Requests are sorted by kind into two small, fully associative tables keyed on the cache-line address: loads and instruction fetches go into the read table, and every store-class operation goes into the write table. Each new request receives a one-cycle accept/refuse answer. An accepted request also gets a fresh request ID. When the cache side signals completion for a line, the matching entry is retired. On the next cycle the block reports the ID that was retired and how many cycles the request was outstanding.

A periodic watchdog runs only while work is pending. It raises a sticky deadlock flag when some entry has been outstanding for at least the threshold. Two further sticky flags report integrity problems: a completion that finds no matching entry, and a running count that no longer agrees with the table contents.

Top module: `inflight_tracker`

## Requirements
- R1: Request kinds are 3-bit codes. Load (0) and instruction fetch (1) are held in the read table. Store (2), atomic read (3), atomic write (4), locked read (5) and locked write (6) are held in the write table. A completion is retired only from the table of its own class.
- R2: A valid request whose line address is present in either table is refused with status 1 (aliased). This refusal takes precedence over the capacity refusal.
- R3: A valid, non-aliased request is refused with status 2 (full) in two cases: the outstanding count is at or above MAX_OUT, or the table for its class has no free slot. Otherwise it is accepted with status 0.
- R4: A request is refused with status 3 (invalid) when its byte offset within the line plus its length exceeds LINE_BYTES, or when its kind is 7. This check comes before all others.
- R5: The ID of an accepted request is the value of an ID counter that starts at 0 after reset and advances by one on each acceptance only.
- R6: A completion that finds its line asserts the matching retire-valid output for exactly one cycle, starting the cycle after the completion. It carries the stored ID and a latency equal to the number of clock edges from acceptance to completion.
- R7: A completion whose line is not in its class's table sets the sticky stray_err flag and changes no entry or count.
- R8: `outstanding` equals the accepted requests minus the retired ones, never exceeds MAX_OUT, and always agrees with the table occupancy. A disagreement would set the sticky count_err flag.
- R9: The watchdog is armed by an acceptance while it is idle and checks every THRESH cycles. It sets the sticky deadlock_flag if some entry's age is at least THRESH. It re-arms only while requests remain outstanding.
- R10: After reset the tables are empty, `outstanding` is 0, and all flags and retire-valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request present this cycle |
| req_kind | input | 3 | Request kind code |
| req_addr | input | 16 | Byte address of the request |
| req_len | input | 5 | Length in bytes |
| req_status | output | 2 | 0 accepted, 1 aliased, 2 full, 3 invalid (same cycle) |
| req_id | output | 8 | ID given to the request when accepted |
| rd_done_valid | input | 1 | Read-class completion present |
| rd_done_line | input | 12 | Line address of the read completion |
| wr_done_valid | input | 1 | Write-class completion present |
| wr_done_line | input | 12 | Line address of the write completion |
| rd_ret_valid | output | 1 | A read entry was retired |
| rd_ret_id | output | 8 | ID of the retired read entry |
| rd_ret_latency | output | 16 | Cycles the read entry was outstanding |
| wr_ret_valid | output | 1 | A write entry was retired |
| wr_ret_id | output | 8 | ID of the retired write entry |
| wr_ret_latency | output | 16 | Cycles the write entry was outstanding |
| outstanding | output | 3 | Number of requests in flight |
| deadlock_flag | output | 1 | Sticky: an aged entry was seen at a watchdog check |
| stray_err | output | 1 | Sticky: a completion matched no entry |
| count_err | output | 1 | Sticky: count and table occupancy disagreed |

## Verification
The bench makes the write table run out of slots while the global count still has room. It then expects full for stores while loads are still accepted; a design that tested only the global limit would accept a fifth store, and one with the class routing wrong would refuse the loads. It sends requests to lines already in flight while the block is at its global limit. The answer must be aliased, never full, which catches a reversed priority. It places the length/offset boundary exactly at the line end and one byte past it, which exposes an off-by-one in the invalid check. A completion is also made to race a new request to the same line, and one request is left outstanding past two watchdog periods. A latency off by one cycle, a watchdog that never fires, or a stray completion that silently decrements the count each shows up as a mismatch.

// File: rtl/inflight_pkg.sv
package inflight_pkg;

   typedef enum logic [2:0] {
      K_LOAD    = 3'd0,
      K_FETCH   = 3'd1,
      K_STORE   = 3'd2,
      K_ATOM_RD = 3'd3,
      K_ATOM_WR = 3'd4,
      K_LOCK_RD = 3'd5,
      K_LOCK_WR = 3'd6,
      K_RSVD    = 3'd7
   } req_kind_e;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_ALIAS = 2'd1,
      ST_FULL  = 2'd2,
      ST_BAD   = 2'd3
   } req_status_e;

   function automatic logic kind_is_write(input req_kind_e k);
      return (k == K_STORE) || (k == K_ATOM_RD) || (k == K_ATOM_WR) ||
             (k == K_LOCK_RD) || (k == K_LOCK_WR);
   endfunction

   function automatic logic kind_is_legal(input req_kind_e k);
      return k != K_RSVD;
   endfunction

endpackage

// File: rtl/inflight_table.sv
module inflight_table
   import inflight_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int LINE_W = 12,
   parameter int ID_W   = 8,
   parameter int TIME_W = 16,
   parameter int OCC_W  = 3,
   parameter int THRESH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] q_line,
   output logic              q_hit,
   output logic              has_room,
   input  logic              ins_en,
   input  logic [ID_W-1:0]   ins_id,
   input  req_kind_e         ins_kind,
   input  logic [TIME_W-1:0] now,
   input  logic              del_en,
   input  logic [LINE_W-1:0] del_line,
   output logic              del_found,
   output logic [ID_W-1:0]   del_id,
   output req_kind_e         del_kind,
   output logic [TIME_W-1:0] del_stamp,
   output logic [OCC_W-1:0]  occ,
   output logic              aged_any
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1) begin : g_bad_depth
      $error("inflight_table: DEPTH must be at least 1");
   end
   if ((1 << OCC_W) <= DEPTH) begin : g_bad_occ
      $error("inflight_table: OCC_W too narrow for DEPTH");
   end

   logic [DEPTH-1:0]  valid_q;
   logic [LINE_W-1:0] line_q  [DEPTH];
   logic [ID_W-1:0]   id_q    [DEPTH];
   req_kind_e         kind_q  [DEPTH];
   logic [TIME_W-1:0] stamp_q [DEPTH];

   logic [IDX_W-1:0]  free_idx;
   logic [IDX_W-1:0]  del_idx;

   always_comb begin
      q_hit     = 1'b0;
      has_room  = 1'b0;
      free_idx  = '0;
      del_found = 1'b0;
      del_idx   = '0;
      aged_any  = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_q[i]) begin
            has_room = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (valid_q[i] && line_q[i] == q_line) q_hit = 1'b1;
         if (valid_q[i] && line_q[i] == del_line) begin
            del_found = 1'b1;
            del_idx   = IDX_W'(i);
         end
         if (valid_q[i] && ((now - stamp_q[i]) >= TIME_W'(THRESH))) aged_any = 1'b1;
      end
      del_id    = id_q[del_idx];
      del_kind  = kind_q[del_idx];
      del_stamp = stamp_q[del_idx];
      occ       = OCC_W'($countones(valid_q));
   end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[gi] <= 1'b0;
            line_q[gi]  <= '0;
            id_q[gi]    <= '0;
            kind_q[gi]  <= K_LOAD;
            stamp_q[gi] <= '0;
         end else begin
            if (del_en && del_found && del_idx == IDX_W'(gi)) valid_q[gi] <= 1'b0;
            if (ins_en && has_room && free_idx == IDX_W'(gi)) begin
               valid_q[gi] <= 1'b1;
               line_q[gi]  <= q_line;
               id_q[gi]    <= ins_id;
               kind_q[gi]  <= ins_kind;
               stamp_q[gi] <= now;
            end
         end
      end
   end

   // R3: an insertion is only requested when a slot is free
   assert_ins_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> has_room);

   // R2: never insert a line that is already held here
   assert_no_dup_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !q_hit);

   // R8: an insertion without removal grows occupancy by one
   assert_occ_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !(del_en && del_found)) |=> (occ == $past(occ) + OCC_W'(1)));

endmodule

// File: rtl/inflight_watchdog.sv
module inflight_watchdog #(
   parameter int THRESH = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic busy_next,
   input  logic aged_any,
   output logic deadlock
);

   localparam int TW = $clog2(THRESH + 1);

   if (THRESH < 2) begin : g_bad_thresh
      $error("inflight_watchdog: THRESH must be at least 2");
   end

   logic          armed_q;
   logic [TW-1:0] timer_q;
   logic          fire;

   assign fire = armed_q && (timer_q == TW'(THRESH - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         timer_q  <= '0;
         deadlock <= 1'b0;
      end else begin
         if (fire) begin
            if (aged_any) deadlock <= 1'b1;
            armed_q <= busy_next;
            timer_q <= '0;
         end else if (armed_q) begin
            timer_q <= timer_q + TW'(1);
         end else if (arm) begin
            armed_q <= 1'b1;
            timer_q <= '0;
         end
      end
   end

   // R9: the period counter never passes the threshold
   assert_timer_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (timer_q < TW'(THRESH)));

   // R9: an idle watchdog is woken by an acceptance
   assert_arm_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && arm) |=> armed_q);

endmodule

// File: rtl/inflight_tracker.sv
module inflight_tracker
   import inflight_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 16,
   parameter int LEN_W      = 5,
   parameter int RD_DEPTH   = 4,
   parameter int WR_DEPTH   = 4,
   parameter int MAX_OUT    = 6,
   parameter int THRESH     = 64,
   parameter int ID_W       = 8,
   parameter int TIME_W     = 16,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = ADDR_W - OFF_W,
   localparam int CNT_W     = $clog2(MAX_OUT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic [1:0]        req_status,
   output logic [ID_W-1:0]   req_id,
   input  logic              rd_done_valid,
   input  logic [LINE_W-1:0] rd_done_line,
   input  logic              wr_done_valid,
   input  logic [LINE_W-1:0] wr_done_line,
   output logic              rd_ret_valid,
   output logic [ID_W-1:0]   rd_ret_id,
   output logic [TIME_W-1:0] rd_ret_latency,
   output logic              wr_ret_valid,
   output logic [ID_W-1:0]   wr_ret_id,
   output logic [TIME_W-1:0] wr_ret_latency,
   output logic [CNT_W-1:0]  outstanding,
   output logic              deadlock_flag,
   output logic              stray_err,
   output logic              count_err
);

   localparam int RD_OCC_W = $clog2(RD_DEPTH + 1);
   localparam int WR_OCC_W = $clog2(WR_DEPTH + 1);

   if ((LINE_BYTES < 2) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
      $error("inflight_tracker: LINE_BYTES must be a power of two");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("inflight_tracker: ADDR_W must exceed the offset width");
   end
   if (MAX_OUT < 1) begin : g_bad_max
      $error("inflight_tracker: MAX_OUT must be at least 1");
   end

   req_kind_e         kind;
   logic [LINE_W-1:0] line;
   logic [OFF_W-1:0]  off;
   logic              is_wr, bad, alias_hit, room, accept;
   logic              rd_hit, wr_hit, rd_room, wr_room;
   logic              rd_found, wr_found, rd_ins, wr_ins;
   logic              rd_aged, wr_aged;
   logic [ID_W-1:0]   rd_del_id, wr_del_id;
   req_kind_e         rd_del_kind, wr_del_kind;
   logic [TIME_W-1:0] rd_del_stamp, wr_del_stamp;
   logic [RD_OCC_W-1:0] rd_occ;
   logic [WR_OCC_W-1:0] wr_occ;
   logic [ID_W-1:0]   id_q;
   logic [TIME_W-1:0] now_q;
   logic [CNT_W-1:0]  count_q, count_next;
   req_status_e       status;

   assign kind  = req_kind_e'(req_kind);
   assign line  = req_addr[ADDR_W-1:OFF_W];
   assign off   = req_addr[OFF_W-1:0];
   assign is_wr = kind_is_write(kind);
   assign bad   = !kind_is_legal(kind) || ((int'(off) + int'(req_len)) > LINE_BYTES);
   assign alias_hit = rd_hit || wr_hit;
   assign room  = is_wr ? wr_room : rd_room;

   always_comb begin
      if (bad)                                          status = ST_BAD;
      else if (alias_hit)                               status = ST_ALIAS;
      else if ((count_q >= CNT_W'(MAX_OUT)) || !room)   status = ST_FULL;
      else                                              status = ST_OK;
   end

   assign accept     = req_valid && (status == ST_OK);
   assign rd_ins     = accept && !is_wr;
   assign wr_ins     = accept && is_wr;
   assign req_status = status;
   assign req_id     = id_q;

   inflight_table #(
      .DEPTH(RD_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .TIME_W(TIME_W),
      .OCC_W(RD_OCC_W), .THRESH(THRESH)
   ) u_rd_tab (
      .clk(clk), .rst_n(rst_n), .q_line(line), .q_hit(rd_hit), .has_room(rd_room),
      .ins_en(rd_ins), .ins_id(id_q), .ins_kind(kind), .now(now_q),
      .del_en(rd_done_valid), .del_line(rd_done_line), .del_found(rd_found),
      .del_id(rd_del_id), .del_kind(rd_del_kind), .del_stamp(rd_del_stamp),
      .occ(rd_occ), .aged_any(rd_aged)
   );

   inflight_table #(
      .DEPTH(WR_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .TIME_W(TIME_W),
      .OCC_W(WR_OCC_W), .THRESH(THRESH)
   ) u_wr_tab (
      .clk(clk), .rst_n(rst_n), .q_line(line), .q_hit(wr_hit), .has_room(wr_room),
      .ins_en(wr_ins), .ins_id(id_q), .ins_kind(kind), .now(now_q),
      .del_en(wr_done_valid), .del_line(wr_done_line), .del_found(wr_found),
      .del_id(wr_del_id), .del_kind(wr_del_kind), .del_stamp(wr_del_stamp),
      .occ(wr_occ), .aged_any(wr_aged)
   );

   assign count_next = count_q + CNT_W'(accept)
                       - CNT_W'(rd_done_valid && rd_found)
                       - CNT_W'(wr_done_valid && wr_found);

   inflight_watchdog #(.THRESH(THRESH)) u_wdog (
      .clk(clk), .rst_n(rst_n), .arm(accept), .busy_next(count_next != '0),
      .aged_any(rd_aged || wr_aged), .deadlock(deadlock_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q           <= '0;
         now_q          <= '0;
         count_q        <= '0;
         rd_ret_valid   <= 1'b0;
         rd_ret_id      <= '0;
         rd_ret_latency <= '0;
         wr_ret_valid   <= 1'b0;
         wr_ret_id      <= '0;
         wr_ret_latency <= '0;
         stray_err      <= 1'b0;
         count_err      <= 1'b0;
      end else begin
         now_q        <= now_q + TIME_W'(1);
         count_q      <= count_next;
         if (accept) id_q <= id_q + ID_W'(1);
         rd_ret_valid <= rd_done_valid && rd_found;
         wr_ret_valid <= wr_done_valid && wr_found;
         if (rd_done_valid && rd_found) begin
            rd_ret_id      <= rd_del_id;
            rd_ret_latency <= now_q - rd_del_stamp;
         end
         if (wr_done_valid && wr_found) begin
            wr_ret_id      <= wr_del_id;
            wr_ret_latency <= now_q - wr_del_stamp;
         end
         if ((rd_done_valid && !rd_found) || (wr_done_valid && !wr_found)) stray_err <= 1'b1;
         if (int'(count_q) != int'(rd_occ) + int'(wr_occ)) count_err <= 1'b1;
      end
   end

   assign outstanding = count_q;

   // R8: running count agrees with the two tables
   assert_count_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count_q) == int'(rd_occ) + int'(wr_occ));

   // R3: never more than the configured number in flight
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(MAX_OUT));

   // R1: the write table only ever retires store-class entries
   assert_wr_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done_valid && wr_found) |-> kind_is_write(wr_del_kind));

   // R1: the read table only ever retires load or fetch entries
   assert_rd_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done_valid && rd_found) |-> !kind_is_write(rd_del_kind));

   // R6: a matched completion is reported on the next cycle
   assert_ret_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done_valid && rd_found) |=> rd_ret_valid);

   // R5: the ID advances only when a request is taken
   assert_id_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(id_q));

endmodule

// File: tb/tb_inflight_tracker.sv
module tb_inflight_tracker;

   localparam int CLK_PERIOD = 10;
   localparam int LB     = 16;
   localparam int RDD    = 4;
   localparam int WRD    = 4;
   localparam int MAXO   = 6;
   localparam int THR    = 64;
   localparam int NLINES = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = '0;
   logic [15:0] req_addr = '0;
   logic [4:0]  req_len = '0;
   logic [1:0]  req_status;
   logic [7:0]  req_id;
   logic        rd_done_valid = 1'b0;
   logic [11:0] rd_done_line = '0;
   logic        wr_done_valid = 1'b0;
   logic [11:0] wr_done_line = '0;
   logic        rd_ret_valid, wr_ret_valid;
   logic [7:0]  rd_ret_id, wr_ret_id;
   logic [15:0] rd_ret_latency, wr_ret_latency;
   logic [2:0]  outstanding;
   logic        deadlock_flag, stray_err, count_err;

   always #(CLK_PERIOD / 2) clk = ~clk;

   inflight_tracker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_len(req_len), .req_status(req_status), .req_id(req_id),
      .rd_done_valid(rd_done_valid), .rd_done_line(rd_done_line),
      .wr_done_valid(wr_done_valid), .wr_done_line(wr_done_line),
      .rd_ret_valid(rd_ret_valid), .rd_ret_id(rd_ret_id), .rd_ret_latency(rd_ret_latency),
      .wr_ret_valid(wr_ret_valid), .wr_ret_id(wr_ret_id), .wr_ret_latency(wr_ret_latency),
      .outstanding(outstanding), .deadlock_flag(deadlock_flag),
      .stray_err(stray_err), .count_err(count_err)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int next_id = 0;
   int nrd = 0, nwr = 0;
   bit mv [NLINES];
   bit mw [NLINES];
   int mid [NLINES];
   int mt [NLINES];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit wr_class(input int k);
      return (k >= 2) && (k <= 6);
   endfunction

   function automatic int exp_status(input int k, input int ln, input int off, input int len);
      if (k == 7 || off + len > LB) return 3;
      if (mv[ln]) return 1;
      if (nrd + nwr >= MAXO) return 2;
      if (wr_class(k) ? (nwr >= WRD) : (nrd >= RDD)) return 2;
      return 0;
   endfunction

   task automatic do_cycle(input bit rv, input int k, input int ln, input int off, input int len,
                           input bit rdv, input int rdl, input bit wrv, input int wrl,
                           output int got);
      int es;
      bit rfound, wfound;
      int rid, rlat, wid, wlat;
      req_valid     = rv;
      req_kind      = 3'(k);
      req_addr      = {12'(ln), 4'(off)};
      req_len       = 5'(len);
      rd_done_valid = rdv;
      rd_done_line  = 12'(rdl);
      wr_done_valid = wrv;
      wr_done_line  = 12'(wrl);
      #1;
      got = int'(req_status);
      es  = exp_status(k, ln, off, len);
      if (rv) begin
         case (es)
            3: chk(got == es, "R4 status", got, es);
            1: chk(got == es, "R2 status", got, es);
            2: chk(got == es, "R3 status", got, es);
            default: chk(got == es, "R1 status", got, es);
         endcase
         if (es == 0) chk(int'(req_id) == (next_id & 255), "R5 id", req_id, next_id & 255);
      end
      rfound = rdv && mv[rdl] && !mw[rdl];
      wfound = wrv && mv[wrl] && mw[wrl];
      rid = rfound ? mid[rdl] : 0;
      rlat = rfound ? cyc - mt[rdl] : 0;
      wid = wfound ? mid[wrl] : 0;
      wlat = wfound ? cyc - mt[wrl] : 0;
      @(posedge clk);
      if (rfound) begin mv[rdl] = 0; nrd--; end
      if (wfound) begin mv[wrl] = 0; nwr--; end
      if (rv && es == 0) begin
         mv[ln] = 1; mw[ln] = wr_class(k); mid[ln] = next_id & 255; mt[ln] = cyc;
         if (wr_class(k)) nwr++; else nrd++;
         next_id++;
      end
      cyc++;
      #1;
      chk(rd_ret_valid == rfound, "R6 rd valid", rd_ret_valid, rfound);
      chk(wr_ret_valid == wfound, "R1 wr valid", wr_ret_valid, wfound);
      if (rfound) begin
         chk(int'(rd_ret_id) == rid, "R6 rd id", rd_ret_id, rid);
         chk(int'(rd_ret_latency) == rlat, "R6 rd latency", rd_ret_latency, rlat);
      end
      if (wfound) begin
         chk(int'(wr_ret_id) == wid, "R6 wr id", wr_ret_id, wid);
         chk(int'(wr_ret_latency) == wlat, "R6 wr latency", wr_ret_latency, wlat);
      end
      chk(int'(outstanding) == nrd + nwr, "R8 outstanding", outstanding, nrd + nwr);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      int g;
      for (int i = 0; i < n; i++) do_cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, g);
   endtask

   task automatic drain();
      int g;
      for (int ln = 0; ln < NLINES; ln++) begin
         if (mv[ln]) begin
            if (mw[ln]) do_cycle(0, 0, 0, 0, 0, 0, 0, 1, ln, g);
            else        do_cycle(0, 0, 0, 0, 0, 1, ln, 0, 0, g);
         end
      end
   endtask

   function automatic int pick(input bit want_wr);
      int s;
      s = $urandom % NLINES;
      for (int j = 0; j < NLINES; j++) begin
         int ln;
         ln = (s + j) % NLINES;
         if (mv[ln] && mw[ln] == want_wr && ((cyc - mt[ln] >= 20) || ($urandom % 2 == 0)))
            return ln;
      end
      return -1;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int g, k, ln, off, len, rl, wl;
      void'($urandom(32'd1234));
      for (int i = 0; i < NLINES; i++) begin mv[i] = 0; mw[i] = 0; mid[i] = 0; mt[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: state after reset
      chk(outstanding == 0, "R10 outstanding", outstanding, 0);
      chk(!rd_ret_valid && !wr_ret_valid, "R10 ret valid", rd_ret_valid | wr_ret_valid, 0);
      chk(!deadlock_flag && !stray_err && !count_err, "R10 flags",
          {deadlock_flag, stray_err, count_err}, 0);
      @(negedge clk);

      // random traffic on a small line set to provoke aliasing and full
      for (int i = 0; i < 1500; i++) begin
         k   = ($urandom % 16 < 14) ? int'($urandom % 7) : 7;
         ln  = $urandom % NLINES;
         off = $urandom % LB;
         len = ($urandom % 8 == 0) ? int'($urandom % 20) : int'($urandom % (LB + 1 - off));
         rl  = pick(0);
         wl  = pick(1);
         do_cycle($urandom % 3 != 0, k, ln, off, len,
                  rl >= 0, (rl >= 0) ? rl : 0, wl >= 0, (wl >= 0) ? wl : 0, g);
      end
      drain();
      idle(2);
      chk(!deadlock_flag, "R9 no false deadlock", deadlock_flag, 0);
      chk(!stray_err, "R7 no stray", stray_err, 0);
      chk(!count_err, "R8 count agrees", count_err, 0);

      // R4 boundary: offset+len exactly the line size is accepted, one more is not
      do_cycle(1, 0, 1, 12, 4, 0, 0, 0, 0, g);
      chk(g == 0, "R4 at boundary", g, 0);
      do_cycle(1, 0, 2, 12, 5, 0, 0, 0, 0, g);
      chk(g == 3, "R4 past boundary", g, 3);
      do_cycle(1, 7, 3, 0, 1, 0, 0, 0, 0, g);
      chk(g == 3, "R4 reserved kind", g, 3);
      // R4 before R2: bad length to a live line still invalid
      do_cycle(1, 0, 1, 15, 9, 0, 0, 0, 0, g);
      chk(g == 3, "R4 over alias", g, 3);
      drain();

      // R3 per-table limit and R1 class routing
      for (int i = 0; i < 4; i++) begin
         do_cycle(1, 2 + i, i, 0, 4, 0, 0, 0, 0, g);
         chk(g == 0, "R1 store accepted", g, 0);
      end
      do_cycle(1, 6, 4, 0, 4, 0, 0, 0, 0, g);
      chk(g == 2, "R3 write table full", g, 2);
      do_cycle(1, 0, 5, 0, 4, 0, 0, 0, 0, g);
      chk(g == 0, "R1 load still fits", g, 0);
      do_cycle(1, 1, 6, 0, 4, 0, 0, 0, 0, g);
      chk(g == 0, "R1 fetch fits", g, 0);
      do_cycle(1, 0, 7, 0, 4, 0, 0, 0, 0, g);
      chk(g == 2, "R3 global limit", g, 2);
      do_cycle(1, 0, 0, 0, 4, 0, 0, 0, 0, g);
      chk(g == 1, "R2 alias over full (write line)", g, 1);
      do_cycle(1, 2, 5, 0, 4, 0, 0, 0, 0, g);
      chk(g == 1, "R2 alias over full (read line)", g, 1);
      // completion racing a request to the same line: still aliased
      do_cycle(1, 0, 5, 0, 4, 1, 5, 0, 0, g);
      chk(g == 1, "R2 alias during retire", g, 1);
      drain();

      // R9 deadlock: leave one load outstanding past two periods
      do_cycle(1, 0, 2, 0, 4, 0, 0, 0, 0, g);
      idle(2 * THR + 4);
      chk(deadlock_flag == 1'b1, "R9 deadlock raised", deadlock_flag, 1);
      drain();

      // R7 stray completion: no entry, count unchanged
      do_cycle(0, 0, 0, 0, 0, 1, 3, 0, 0, g);
      chk(stray_err == 1'b1, "R7 stray flagged", stray_err, 1);
      chk(outstanding == 0, "R7 count unchanged", outstanding, 0);
      chk(!count_err, "R8 final", count_err, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule